// File: doc/BRIEF.md
# Timer Capture/Compare Channel Unit

This block is a free-running 16-bit up-counter with a group of timing channels built around it. Three channels capture the counter when their input pin shows a chosen edge. Four channels compare the counter against a stored target. A fifth, shared channel can work either way, and a run-time mode bit selects which. Compare channels 2 to 5 each drive one output pin. When the counter equals the target, a two-bit action code sets what happens to that pin. Compare channel 1 raises its flag and drives no pin.

Every channel has an event flag and an interrupt mask bit. The counter wrap has its own flag and mask as well. A single interrupt line gathers all flags whose mask bits are set. Software reaches the control words, the flags, the masks, the counter and the channel registers through a simple word-wide register port. Writes are synchronous and reads are combinational.

Top module: `tmr_cc_unit`

## Requirements
- R1: After reset, the control word, the mask word, the flag word and the mode bit read zero. The capture registers read 0. Compare registers 1 to 4 and the shared register read 16'hFFFF. All compare pins are low and irq is low.
- R2: The counter (address 0) increments by one on each clock with `tick` high and holds otherwise. When it steps from 16'hFFFF to 0, it sets flag bit 0 (overflow) on that same edge.
- R3: When `tick` is high and the counter equals the target of an enabled compare channel, that channel's flag is set on that edge and not before. Flag bits 4..7 belong to compare channels 1..4, and bit 8 belongs to the shared channel.
- R4: In the same edge as the match, pin action code 00 leaves the pin unchanged, 01 inverts it, 10 drives it low and 11 drives it high.
- R5: Capture edge code 00 captures nothing, 01 captures rising edges, 10 captures falling edges and 11 captures both. On a selected edge, the capture register takes the counter value and the channel flag is set. Flag bits 1..3 belong to capture channels 1..3. Both results are visible three clock edges after the pin changes.
- R6: Mode bit 0 of address 4 selects the shared channel: 0 means capture (edge code in control bits 7:6, result in address 12) and 1 means compare (target in address 12). In capture mode the shared channel never produces a compare match. In compare mode its pin edges are ignored.
- R7: Writing the flag word (address 3) clears each flag whose data bit is 1 and leaves the others unchanged.
- R8: `irq` is high exactly when some flag bit is set and the mask word (address 2, same bit layout as the flags) has the same bit set.
- R9: Control word (address 1) layout: bits 15:14, 13:12, 11:10 and 9:8 hold the pin action codes of compare channels 5, 4, 3 and 2. Bits 7:6, 5:4, 3:2 and 1:0 hold the edge codes of capture channels 4 (shared), 3, 2 and 1. It reads back as written.
- R10: Writes to the counter (address 0) and to capture registers 1..3 (addresses 5..7) have no effect. Compare registers 1..4 sit at addresses 8..11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| cap_in | input | 4 | Capture pins; bit 3 is the shared channel |
| cmp_out | output | 4 | Compare pins of channels 2..5 |
| irq | output | 1 | Masked OR of all flags |

## Verification
Register reads are combinational, so the bench samples them one time step after it drives the address. A compare flag and its pin move on the edge of the matching tick. The bench therefore reads the flags once after the tick just before the match, expecting nothing, and once after the matching tick. A capture passes two synchronizer stages and one latch stage, so it lands three edges after the pin change. The bench freezes the counter, waits four edges and expects the frozen count. The overflow flag is checked on the edge after the last tick at 16'hFFFF, and again on the tick before it.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  localparam int unsigned A_CNT  = 0;
  localparam int unsigned A_CTL  = 1;
  localparam int unsigned A_MSK  = 2;
  localparam int unsigned A_FLG  = 3;
  localparam int unsigned A_MODE = 4;
  localparam int unsigned A_CAP0 = 5;

  // Edge qualifier for a capture channel: prv/cur are successive synced samples.
  function automatic logic edge_hit(input logic [1:0] code, input logic prv, input logic cur);
    case (code)
      2'b01:   return !prv && cur;
      2'b10:   return prv && !cur;
      2'b11:   return prv ^ cur;
      default: return 1'b0;
    endcase
  endfunction

  // Pin value after a compare match for a given action code.
  function automatic logic pin_next(input logic [1:0] code, input logic pin);
    case (code)
      2'b01:   return ~pin;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return pin;
    endcase
  endfunction

endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         wrap_evt
);
  assign wrap_evt = tick && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_cap_ch.sv
module tmr_cap_ch
  import tmr_cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] code,
  input  logic       enable,
  output logic       evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign evt = enable && edge_hit(code, s3, s2);
endmodule

// File: rtl/tmr_cmp_ch.sv
module tmr_cmp_ch #(
  parameter int unsigned W = 16
) (
  input  logic         tick,
  input  logic         enable,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] tgt,
  output logic         evt
);
  assign evt = enable && tick && (cnt == tgt);
endmodule

// File: rtl/tmr_cc_unit.sv
module tmr_cc_unit
  import tmr_cc_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned N_CAP = 3,
  parameter int unsigned N_CMP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [N_CAP:0] cap_in,
  output logic [N_CMP-1:0] cmp_out,
  output logic          irq
);
  localparam int unsigned EDG_W  = 2 * (N_CAP + 1);
  localparam int unsigned CTL_W  = EDG_W + 2 * N_CMP;
  localparam int unsigned FLG_W  = N_CAP + N_CMP + 2;
  localparam int unsigned A_CMP0 = A_CAP0 + N_CAP;
  localparam int unsigned A_SHR  = A_CMP0 + N_CMP;

  logic [W-1:0]     cnt_w;
  logic             ovf_evt;
  logic [N_CAP:0]   cap_evt;
  logic [N_CMP:0]   cmp_evt;
  logic [CTL_W-1:0] ctl_q;
  logic [FLG_W-1:0] msk_q, flg_q, flg_d;
  logic             mode_q;
  logic [W-1:0]     cap_q [N_CAP];
  logic [W-1:0]     cmp_q [N_CMP];
  logic [W-1:0]     shr_q;

  tmr_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_w), .wrap_evt(ovf_evt)
  );

  for (genvar i = 0; i <= N_CAP; i++) begin : g_cap
    tmr_cap_ch u_ch (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[i]), .code(ctl_q[2*i +: 2]),
      .enable((i == N_CAP) ? ~mode_q : 1'b1), .evt(cap_evt[i])
    );
  end

  for (genvar j = 0; j <= N_CMP; j++) begin : g_cmp
    logic [W-1:0] tgt;
    if (j < N_CMP) begin : g_own
      assign tgt = cmp_q[j];
    end else begin : g_shr
      assign tgt = shr_q;
    end
    tmr_cmp_ch #(.W(W)) u_ch (
      .tick(tick), .enable((j == N_CMP) ? mode_q : 1'b1), .cnt(cnt_w),
      .tgt(tgt), .evt(cmp_evt[j])
    );
  end

  for (genvar j = 1; j <= N_CMP; j++) begin : g_pin
    logic [1:0] code;
    logic       pin_r;
    assign code = ctl_q[EDG_W + 2*(j-1) +: 2];
    always_ff @(posedge clk) begin
      if (!rst_n)          pin_r <= 1'b0;
      else if (cmp_evt[j]) pin_r <= pin_next(code, pin_r);
    end
    assign cmp_out[j-1] = pin_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      msk_q  <= '0;
      mode_q <= 1'b0;
      for (int j = 0; j < N_CMP; j++) cmp_q[j] <= '1;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_CTL))  ctl_q  <= bus_wdata[CTL_W-1:0];
      if (bus_addr == AW'(A_MSK))  msk_q  <= bus_wdata[FLG_W-1:0];
      if (bus_addr == AW'(A_MODE)) mode_q <= bus_wdata[0];
      for (int j = 0; j < N_CMP; j++)
        if (bus_addr == AW'(A_CMP0 + j)) cmp_q[j] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CAP; i++) cap_q[i] <= '0;
      shr_q <= '1;
    end else begin
      for (int i = 0; i < N_CAP; i++)
        if (cap_evt[i]) cap_q[i] <= cnt_w;
      if (cap_evt[N_CAP])                           shr_q <= cnt_w;
      else if (bus_we && bus_addr == AW'(A_SHR))    shr_q <= bus_wdata;
    end
  end

  always_comb begin
    flg_d = flg_q;
    if (bus_we && bus_addr == AW'(A_FLG)) flg_d = flg_q & ~bus_wdata[FLG_W-1:0];
    flg_d[0] = flg_d[0] | ovf_evt;
    for (int i = 0; i < N_CAP; i++)  flg_d[1+i] = flg_d[1+i] | cap_evt[i];
    for (int j = 0; j <= N_CMP; j++) flg_d[1+N_CAP+j] = flg_d[1+N_CAP+j] | cmp_evt[j];
    flg_d[FLG_W-1] = flg_d[FLG_W-1] | cap_evt[N_CAP];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign irq = |(flg_q & msk_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_CNT))  bus_rdata = cnt_w;
    if (bus_addr == AW'(A_CTL))  bus_rdata[CTL_W-1:0] = ctl_q;
    if (bus_addr == AW'(A_MSK))  bus_rdata[FLG_W-1:0] = msk_q;
    if (bus_addr == AW'(A_FLG))  bus_rdata[FLG_W-1:0] = flg_q;
    if (bus_addr == AW'(A_MODE)) bus_rdata[0] = mode_q;
    for (int i = 0; i < N_CAP; i++)
      if (bus_addr == AW'(A_CAP0 + i)) bus_rdata = cap_q[i];
    for (int j = 0; j < N_CMP; j++)
      if (bus_addr == AW'(A_CMP0 + j)) bus_rdata = cmp_q[j];
    if (bus_addr == AW'(A_SHR))  bus_rdata = shr_q;
  end
endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk #(
  parameter int unsigned W     = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned N_CAP = 3,
  parameter int unsigned N_CMP = 4,
  parameter int unsigned FLG_W = N_CAP + N_CMP + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [W-1:0]     bus_wdata,
  input logic [W-1:0]     cnt,
  input logic [FLG_W-1:0] flg,
  input logic [FLG_W-1:0] msk,
  input logic             irq,
  input logic             mode,
  input logic             ovf_evt,
  input logic [N_CAP:0]   cap_evt,
  input logic [N_CMP:0]   cmp_evt
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == W'($past(cnt) + 1'b1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R2
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flg[0]);

  for (genvar j = 0; j <= N_CMP; j++) begin : g_cmp_a
    // R3
    cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt[j] |=> flg[1+N_CAP+j]);
  end

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap_a
    // R5
    cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> flg[1+i]);
  end

  // R6
  shr_cmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> !cmp_evt[N_CMP]);
  // R6
  shr_cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> !cap_evt[N_CAP]);
  // R7
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(3) && bus_wdata[0] && !ovf_evt) |=> !flg[0]);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flg & msk) == '0) |-> !irq);
endmodule

bind tmr_cc_unit tmr_cc_chk #(.W(W), .AW(AW), .N_CAP(N_CAP), .N_CMP(N_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt_w), .flg(flg_q), .msk(msk_q), .irq(irq),
  .mode(mode_q), .ovf_evt(ovf_evt), .cap_evt(cap_evt), .cmp_evt(cmp_evt)
);

// File: tb/tb_tmr_cc_unit.sv
module tb_tmr_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  cmp_out;
  logic        irq;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  logic [15:0] mc = '0;
  logic [3:0]  mpin = '0;
  logic [15:0] mcap [4];
  logic [15:0] d;

  always #4 clk = ~clk;

  tmr_cc_unit dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_out(cmp_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk);
    bus_we = 1'b1;
    bus_addr = a;
    bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tk(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    mc = mc + 16'(n);
  endtask

  function automatic logic act(input logic [1:0] c, input logic p);
    if (c == 2'd0) return p;
    if (c == 2'd1) return !p;
    return c[0];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mcap[i] = (i == 3) ? 16'hFFFF : 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd1, d);  chk("R1 ctl", d, 0);
    rd(4'd2, d);  chk("R1 msk", d, 0);
    rd(4'd3, d);  chk("R1 flg", d, 0);
    rd(4'd4, d);  chk("R1 mode", d, 0);
    rd(4'd5, d);  chk("R1 cap1", d, 0);
    rd(4'd8, d);  chk("R1 cmp1", d, 16'hFFFF);
    rd(4'd12, d); chk("R1 shared", d, 16'hFFFF);
    chk("R1 pins", cmp_out, 0);
    chk("R1 irq", irq, 0);

    // R2 counting and hold
    tk(7);
    rd(4'd0, d); chk("R2 count", d, mc);
    @(negedge clk); @(negedge clk);
    rd(4'd0, d); chk("R2 hold", d, mc);

    // R10 read-only registers
    wr(4'd0, 16'h1234); rd(4'd0, d); chk("R10 cnt write ignored", d, mc);
    wr(4'd5, 16'h4321); rd(4'd5, d); chk("R10 cap write ignored", d, 0);
    wr(4'd9, 16'hBEEF); rd(4'd9, d); chk("R10 cmp2 addr", d, 16'hBEEF);

    // R3/R4 compare sweep over action codes, shared channel in compare mode (R6)
    wr(4'd4, 16'h0001);
    for (int c = 0; c < 4; c++) begin
      logic [1:0] cc;
      cc = 2'(c);
      wr(4'd1, {cc, cc, cc, cc, 8'h00});
      rd(4'd1, d); chk("R9 ctl readback", d, {cc, cc, cc, cc, 8'h00});
      for (int a = 8; a <= 12; a++) wr(4'(a), mc + 16'd2);
      wr(4'd3, 16'h01FF);
      tk(2);
      rd(4'd3, d); chk("R3 no early flag", d, 0);
      chk("R4 pins before match", cmp_out, mpin);
      tk(1);
      for (int k = 0; k < 4; k++) mpin[k] = act(cc, mpin[k]);
      rd(4'd3, d); chk("R3 match flags", d, 16'h01F0);
      chk("R4 pin action", cmp_out, mpin);
      tk(1);
      chk("R4 pins hold after match", cmp_out, mpin);
    end

    // R7 write-one-to-clear
    wr(4'd3, 16'h0010); rd(4'd3, d); chk("R7 partial clear", d, 16'h01E0);
    wr(4'd3, 16'h01FF); rd(4'd3, d); chk("R7 full clear", d, 0);

    // R9 field placement: only channel 3 (bits 11:10) drives low
    wr(4'd1, 16'h0800);
    for (int a = 8; a <= 12; a++) wr(4'(a), mc + 16'd1);
    tk(2);
    mpin[1] = 1'b0;
    chk("R9 channel 3 field", cmp_out, mpin);

    // R6 capture mode: shared channel makes no compare match
    wr(4'd4, 16'h0000);
    wr(4'd1, 16'h5500);
    for (int a = 8; a <= 12; a++) wr(4'(a), mc + 16'd1);
    mcap[3] = mc + 16'd1;
    wr(4'd3, 16'h01FF);
    tk(2);
    for (int k = 0; k < 3; k++) mpin[k] = !mpin[k];
    rd(4'd3, d); chk("R6 shared no match in capture mode", d, 16'h00F0);
    chk("R6 shared pin untouched", cmp_out, mpin);

    // R5 capture sweep over edge codes and edge directions
    wr(4'd1, 16'h0000);
    for (int c = 0; c < 4; c++) begin
      for (int dir = 0; dir < 2; dir++) begin
        logic [1:0] cc;
        logic hit;
        cc = 2'(c);
        wr(4'd1, {8'h00, cc, cc, cc, cc});
        tk(5 + c);
        wr(4'd3, 16'h01FF);
        @(negedge clk);
        cap_in = (dir == 0) ? 4'hF : 4'h0;
        repeat (4) @(negedge clk);
        hit = (cc == 2'd3) || (cc == 2'd1 && dir == 0) || (cc == 2'd2 && dir == 1);
        if (hit) for (int i = 0; i < 4; i++) mcap[i] = mc;
        for (int i = 0; i < 3; i++) begin
          rd(4'(5 + i), d); chk("R5 capture value", d, mcap[i]);
        end
        rd(4'd12, d); chk("R5 shared capture value", d, mcap[3]);
        rd(4'd3, d);  chk("R5 capture flags", d, hit ? 16'h010E : 16'h0000);
      end
    end

    // R6 compare mode: shared pin edges ignored
    wr(4'd4, 16'h0001);
    wr(4'd1, 16'h00FF);
    tk(3);
    wr(4'd3, 16'h01FF);
    @(negedge clk);
    cap_in = 4'hF;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) mcap[i] = mc;
    rd(4'd12, d); chk("R6 shared edge ignored", d, mcap[3]);
    rd(4'd3, d);  chk("R6 only dedicated captures flagged", d, 16'h000E);
    rd(4'd6, d);  chk("R5 capture 2 in compare mode", d, mcap[1]);

    // R8 masked interrupt, one mask bit at a time
    for (int b = 0; b < 9; b++) begin
      wr(4'd2, 16'(1 << b));
      @(negedge clk);
      chk("R8 irq per mask bit", irq, (b >= 1 && b <= 3) ? 1 : 0);
    end
    wr(4'd2, 16'h0000);
    @(negedge clk);
    chk("R8 irq all masked", irq, 0);

    // R2 wrap and overflow flag
    for (int a = 8; a <= 12; a++) wr(4'(a), 16'h0005);
    wr(4'd3, 16'h01FF);
    tk(int'(16'hFFFF - mc));
    rd(4'd0, d); chk("R2 at top", d, 16'hFFFF);
    rd(4'd3, d); chk("R2 no overflow yet", d[0], 0);
    tk(1);
    rd(4'd0, d); chk("R2 wrapped", d, 16'h0000);
    rd(4'd3, d); chk("R2 overflow flag", d[0], 1);
    wr(4'd2, 16'h0001);
    @(negedge clk);
    chk("R8 overflow irq", irq, 1);
    wr(4'd3, 16'h0001);
    @(negedge clk);
    chk("R7 overflow cleared irq", irq, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule